// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Channel

This block moves one byte at a time over a three-wire synchronous link: a serial data output, a serial data input and a transfer clock. Software configures it through three byte-wide registers on a small write/read bus. These are a control byte, a bit-rate divider and a shift data register. Writing the data register launches a transfer. Eight bits leave on the data output while eight bits are captured from the data input. The incoming byte can then be read back at the same address.

The transfer clock either comes from an external pin or is built on chip. When built on chip, the system clock passes through a prescaler (divide by 1, 8 or 32) and then through a programmable divide-by-(n+1) counter, and the result drives the clock pin. Control bits choose which transfer-clock edge changes the output and which edge samples the input, the bit order, and whether the pins act as serial pins or as plain port pins with a programmable output level. A separate bit releases the data output to high impedance.

Top module: `sio_sync`

Register addresses on `bus_addr`: 0 is the data register, 1 is the control byte, 2 is the divider, and 3 is unused. Control byte fields: [1:0] prescale, [2] output release, [3] serial-pin mode, [4] edge polarity, [5] MSB-first, [6] internal clock, [7] port-mode output level.

## Requirements
- R1: After reset the control byte reads 0x40. `busy` and `done` are low, `sout_oe` is high, `sout_o` is low and `sck_oe` is low.
- R2: The divider register is write-only, so reads at address 2 and address 3 return 0x00.
- R3: With the internal clock, each half period of `sck_o` lasts (n+1)·P system cycles, where n is the divider value and P is 1, 8 or 32 for prescale codes 00, 01 and 10. A control write whose prescale code is 11 is rejected as a whole and leaves the control byte unchanged.
- R4: When control bit 2 is 1, `sout_oe` is low in every pin mode.
- R5: When control bit 3 is 0, `sout_o` follows control bit 7 and `sck_oe` is low. When bits 3 and 6 are both 1, `sck_oe` is high.
- R6: With polarity bit 4 at 0, the output changes on falling transfer-clock edges and the input is sampled on rising edges, and the internal clock idles high. With bit 4 at 1, both edges swap and the clock idles low.
- R7: With control bit 5 at 0, bit 0 of the data register is sent first and the first received bit lands in bit 0. With bit 5 at 1, bit 7 is used in both cases.
- R8: A write to address 0 while idle starts an 8-bit transfer. After completion, address 0 reads the byte captured from `sin_i`.
- R9: `busy` rises on the cycle after the starting write and falls on the eighth sample edge. At that same edge `done` pulses high for exactly one cycle. Writes to address 0 or address 2 while busy are ignored.
- R10: With control bit 6 at 0, the transfer is clocked by `sck_i` through a two-flop synchronizer, and the shift and sample edges follow R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sin_i | input | 1 | Serial data input |
| sck_i | input | 1 | External transfer clock |
| sout_o | output | 1 | Serial data output value |
| sout_oe | output | 1 | Serial data output enable |
| sck_o | output | 1 | Internal transfer clock output |
| sck_oe | output | 1 | Transfer clock output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random internal-clock transfers vary the data byte, the input byte, the polarity, the bit order, the prescale code and the divider value. A wrong edge choice shows up as sampled output bits that do not match the data. A reversed order shows up as a mirrored byte. A wrong divider chain shows up as half periods of the wrong length. A directed transfer issues data and divider writes while busy, which separates ignored writes from accepted ones. An externally clocked transfer at each polarity shows whether the synchronized clock path drives the same shifting logic. Static pin-mode and tristate patterns, together with a rejected prescale code, cover the control fields that do not need a transfer.

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             sin_i,
  input  logic             sck_i,
  output logic             sout_o,
  output logic             sout_oe,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             busy,
  output logic             done
);
  localparam logic [7:0] CTRL_RST = 8'h40;

  logic [7:0]       ctrl_q, tx_q, rx_q;
  logic [DIV_W-1:0] div_q, dcnt_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [2:0]       cnt_q, idx;
  logic             busy_q, done_q, sck_q, sout_q;
  logic             s1, s2, s3;

  wire pol     = ctrl_q[4];
  wire msb     = ctrl_q[5];
  wire int_clk = ctrl_q[6];

  wire wr_data = bus_wr && bus_addr == 2'd0 && !busy_q;
  wire wr_ctrl = bus_wr && bus_addr == 2'd1 && bus_wdata[1:0] != 2'b11;
  wire wr_div  = bus_wr && bus_addr == 2'd2 && !busy_q;

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   pre_lim = '0;
      2'b01:   pre_lim = PRE_W'(7);
      default: pre_lim = PRE_W'(31);
    endcase
  end

  wire tick   = pre_q == pre_lim;
  wire int_tc = busy_q && int_clk && tick && dcnt_q == div_q;

  wire ext_rise = busy_q && !int_clk && s2 && !s3;
  wire ext_fall = busy_q && !int_clk && !s2 && s3;
  wire rise     = (int_tc && !sck_q) || ext_rise;
  wire fall     = (int_tc && sck_q) || ext_fall;
  wire samp_e   = pol ? fall : rise;
  wire shift_e  = pol ? rise : fall;

  assign idx = msb ? ~cnt_q : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= sck_i; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      dcnt_q <= '0;
      sck_q  <= 1'b1;
    end else if (!busy_q) begin
      pre_q  <= '0;
      dcnt_q <= '0;
      sck_q  <= ~pol;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) dcnt_q <= (dcnt_q == div_q) ? '0 : dcnt_q + 1'b1;
      if (int_tc) sck_q <= ~sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_data) begin
        tx_q   <= bus_wdata;
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sout_q <= msb ? bus_wdata[7] : bus_wdata[0];
      end else if (busy_q) begin
        if (shift_e) sout_q <= tx_q[idx];
        if (samp_e) begin
          rx_q[idx] <= sin_i;
          cnt_q     <= cnt_q + 1'b1;
          if (cnt_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = rx_q;
      2'd1:    bus_rdata = ctrl_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign sout_o  = ctrl_q[3] ? sout_q : ctrl_q[7];
  assign sout_oe = ~ctrl_q[2];
  assign sck_o   = sck_q;
  assign sck_oe  = ctrl_q[3] & int_clk;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/sio_sync_chk.sv
module sio_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       busy,
  input logic       done,
  input logic [7:0] ctrl_q,
  input logic [7:0] div_q,
  input logic [7:0] tx_q
);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !busy) |=> busy);
  a_r9_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && busy) |=> $stable(tx_q));
  a_r9_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && busy) |=> $stable(div_q));
  a_r3_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && bus_wdata[1:0] == 2'b11) |=> $stable(ctrl_q));
endmodule

bind sio_sync sio_sync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .done(done),
  .ctrl_q(ctrl_q), .div_q(div_q), .tx_q(tx_q)
);

// File: tb/sio_sync_tb.sv
module sio_sync_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sin_i = 1'b0;
  logic       sck_i = 1'b1;
  logic       sout_o, sout_oe, sck_o, sck_oe, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  sio_sync u_dut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic bitk(input logic [7:0] d, input bit msbf, input int k);
    return msbf ? d[7-k] : d[k];
  endfunction

  function automatic int plen(input logic [1:0] code);
    return code == 2'b00 ? 1 : (code == 2'b01 ? 8 : 32);
  endfunction

  task automatic run_int(input logic [7:0] ctrl, input logic [7:0] dv,
                         input logic [7:0] data, input logic [7:0] sb, input bit poke);
    logic [7:0] got, rx;
    logic prev, smp_lvl;
    int c, nsamp, ndone, bad_half, cyc;
    bit pol, msbf;
    pol = ctrl[4]; msbf = ctrl[5];
    smp_lvl = pol ? 1'b0 : 1'b1;
    wr(2'd2, dv);
    wr(2'd1, ctrl);
    @(negedge clk);
    check(sck_o == ~pol, "R6 idle level", sck_o, ~pol);
    sin_i = bitk(sb, msbf, 0);
    wr(2'd0, data);
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    prev = sck_o; c = 0; nsamp = 0; ndone = 0; bad_half = 0; got = 0; cyc = 0;
    while (nsamp < 8 && cyc < 20000) begin
      if (poke && cyc == 2) begin bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ~data; end
      else if (poke && cyc == 3) begin bus_addr = 2'd2; bus_wdata = dv + 8'd3; end
      else bus_wr = 1'b0;
      @(negedge clk);
      c++; cyc++;
      if (done) ndone++;
      if (sck_o != prev) begin
        if (c != (int'(dv) + 1) * plen(ctrl[1:0])) bad_half++;
        c = 0;
        if (sck_o == smp_lvl) begin
          got[nsamp] = sout_o;
          nsamp++;
          if (nsamp == 8) begin
            check(done == 1'b1 && busy == 1'b0, "R9 done at last sample", {done, busy}, 2);
          end
        end else begin
          sin_i = bitk(sb, msbf, nsamp);
        end
        prev = sck_o;
      end
    end
    bus_wr = 1'b0;
    @(negedge clk);
    if (done) ndone++;
    check(ndone == 1, "R9 single done pulse", ndone, 1);
    check(bad_half == 0, "R3 half period length", bad_half, 0);
    for (int k = 0; k < 8; k++) begin
      if (got[k] != bitk(data, msbf, k)) begin
        check(0, "R6/R7 sent bits", got, data);
        break;
      end
    end
    check(nsamp == 8, "R8 eight bits", nsamp, 8);
    rd(2'd0, rx);
    check(rx == sb, "R8 R7 received byte", rx, sb);
  endtask

  task automatic run_ext(input bit pol, input bit msbf, input logic [7:0] data, input logic [7:0] sb);
    logic [7:0] rx, ctrl, got;
    int ndone;
    ctrl = {1'b0, 1'b0, msbf, pol, 1'b1, 1'b0, 2'b00};
    sck_i = ~pol;
    wr(2'd1, ctrl);
    check(sck_oe == 1'b0, "R10 clock pin input", sck_oe, 0);
    repeat (4) @(negedge clk);
    sin_i = bitk(sb, msbf, 0);
    wr(2'd0, data);
    ndone = 0; got = 0;
    for (int k = 0; k < 8; k++) begin
      sck_i = pol;
      sin_i = bitk(sb, msbf, k);
      repeat (8) begin @(negedge clk); if (done) ndone++; end
      got[k] = sout_o;
      sck_i = ~pol;
      repeat (8) begin @(negedge clk); if (done) ndone++; end
    end
    check(ndone == 1 && busy == 1'b0, "R10 done once", ndone, 1);
    for (int k = 0; k < 8; k++) begin
      if (got[k] != bitk(data, msbf, k)) begin
        check(0, "R10 sent bits", got, data);
        break;
      end
    end
    rd(2'd0, rx);
    check(rx == sb, "R10 received byte", rx, sb);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, r);
    check(r == 8'h40, "R1 control reset", r, 8'h40);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    check(sout_oe && !sout_o && !sck_oe, "R1 pins", {sout_oe, sout_o, sck_oe}, 3'b100);

    wr(2'd2, 8'h5A);
    rd(2'd2, r);
    check(r == 8'h00, "R2 divider unreadable", r, 0);
    rd(2'd3, r);
    check(r == 8'h00, "R2 unused address", r, 0);

    wr(2'd1, 8'h4B);
    rd(2'd1, r);
    check(r == 8'h40, "R3 reserved code rejected", r, 8'h40);

    wr(2'd1, 8'h84);
    check(sout_oe == 1'b0, "R4 release in port mode", sout_oe, 0);
    wr(2'd1, 8'h4C);
    check(sout_oe == 1'b0, "R4 release in serial mode", sout_oe, 0);

    wr(2'd1, 8'hC0);
    check(sout_o == 1'b1 && sck_oe == 1'b0, "R5 port level high", {sout_o, sck_oe}, 2'b10);
    wr(2'd1, 8'h40);
    check(sout_o == 1'b0, "R5 port level low", sout_o, 0);
    wr(2'd1, 8'h48);
    check(sck_oe == 1'b1, "R5 clock output enabled", sck_oe, 1);

    run_int(8'h48, 8'd0, 8'hA5, 8'h3C, 1'b0);
    run_int(8'h78, 8'd2, 8'h81, 8'hE1, 1'b0);
    run_int(8'h49, 8'd1, 8'h0F, 8'hF2, 1'b0);
    run_int(8'h5A, 8'd0, 8'h96, 8'h71, 1'b0);
    run_int(8'h48, 8'd4, 8'hC3, 8'h5A, 1'b1);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] c, d, s, dv;
      logic [1:0] pc;
      pc = 2'($urandom % 3);
      dv = (pc == 2'b10) ? 8'($urandom % 2) : 8'($urandom % 6);
      c = {1'b0, 1'b1, 1'($urandom), 1'($urandom), 1'b1, 1'b0, pc};
      d = 8'($urandom);
      s = 8'($urandom);
      run_int(c, dv, d, s, 1'b0);
    end

    run_ext(1'b0, 1'b0, 8'h6D, 8'hB4);
    run_ext(1'b1, 1'b1, 8'h2E, 8'h93);
    summary();
  end
endmodule